// File: doc/BRIEF.md
# Luma Edge Enhancer with Coring

This block sharpens a streaming luma plane. Each output sample comes from a 3x3 neighbourhood of the input. The neighbourhood is weighted by nine programmable signed coefficients and the weighted sum is arithmetically shifted right. The result then passes through a dead-zone (coring) stage that pulls it toward zero by a threshold. The cored edge value is added to the centre sample and the result is clamped to the unsigned luma range. A single enable input switches the filter off, and the centre sample then passes through unchanged.

Pixels arrive in raster order with valid/ready handshaking, a start-of-frame marker on the first pixel and an end-of-line marker on the last pixel of each line. Line width and frame height are parameters. Two inferred line memories of line-width depth hold the two previous rows. Outside the image, the window repeats the nearest border pixel, so every frame comes out at the same size it went in. Output lags input by about one line. Markers travel with the data. After the last input pixel of a frame, the block drains the final row by itself, without any further input.

Each line takes one extra internal step, in which the block emits the last pixel of that line using a replicated right neighbour. During that step the block accepts no input.

Top module: `luma_edge_enhancer`

## Requirements
- R1: After reset the output is not valid and the input is ready.
- R2: The edge sum is the sum over the 3x3 window of pixel times coefficient. Coefficient k sits in bits [10k+9:10k] of `coef` as a 10-bit two's-complement value. k = 3*row + column, with row 0 the upper line and column 0 the left pixel.
- R3: The edge sum is shifted right arithmetically (sign kept) by `shift` (0 to 15).
- R4: Coring with threshold T = `thresh` (0 to 63) works as follows. A shifted value above T becomes value minus T. A value below -T becomes value plus T. Any other value becomes zero.
- R5: With `en` = 1 the output is centre pixel plus cored edge, clamped to 0 .. 2^DW-1.
- R6: At the image borders, missing rows and columns take the nearest border pixel.
- R7: With `en` = 0 each output pixel equals the centre input pixel, whatever the coefficients, shift and threshold.
- R8: Each frame yields HEIGHT lines of WIDTH pixels. `out_sof` marks the first output pixel of the frame and `out_eol` marks the last pixel of each line.
- R9: While `out_valid` is high and `out_ready` is low, the output pixel and markers hold. No pixel is lost or repeated under stalls on either side.
- R10: The last row of a frame is produced after the final input pixel with no further input, and nothing extra is emitted afterwards.
- R11: An input pixel with `in_sof` set restarts the frame at row 0, column 0, and a partial earlier frame produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Filter enable; 0 passes luma through |
| coef | input | 90 | Nine signed 10-bit kernel coefficients |
| shift | input | 4 | Right-shift amount for the edge sum |
| thresh | input | 6 | Coring threshold |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_pix | input | DW | Input luma sample |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | DW | Enhanced luma sample |
| out_sof | output | 1 | First output pixel of a frame |
| out_eol | output | 1 | Last output pixel of a line |

## Verification
The row and column counters decide where the window sits and when the border pixel is repeated. A counter that goes off track shows up at the ports within one line as a marker at the wrong place or a pixel taken from a neighbouring position. A stale line-memory entry corrupts every pixel in the following row at that column, so a full-frame comparison against a computed model finds it. Stalls on either side are where a lost or doubled pixel would appear, so the same frames are repeated with gaps in both valid and ready.

// File: rtl/luma_edge_enhancer.sv
module luma_edge_enhancer #(
  parameter int WIDTH  = 64,
  parameter int HEIGHT = 48,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [89:0]   coef,
  input  logic [3:0]    shift,
  input  logic [5:0]    thresh,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_pix,
  input  logic          in_sof,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_pix,
  output logic          out_sof,
  output logic          out_eol
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam int RW = $clog2(HEIGHT + 1);
  localparam int AW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int SW = DW + 15;
  localparam logic [CW-1:0] END_COL = CW'(WIDTH);
  localparam logic [RW-1:0] END_ROW = RW'(HEIGHT);
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [DW-1:0] line1 [WIDTH];
  logic [DW-1:0] line2 [WIDTH];
  logic [3*DW-1:0] prev1, prev2;

  wire out_free = !out_valid || out_ready;
  wire need_in  = (col != END_COL) && (row != END_ROW);
  assign in_ready = out_free && need_in;

  wire resync = in_valid && in_sof && in_ready;
  wire [CW-1:0] c_e = resync ? '0 : col;
  wire [RW-1:0] r_e = resync ? '0 : row;
  wire adv     = out_free && (need_in ? in_valid : 1'b1);
  wire produce = (r_e != '0) && (c_e != '0);
  wire flush   = (r_e == END_ROW);

  wire [AW-1:0] rd_idx = (c_e == END_COL) ? '0 : c_e[AW-1:0];
  wire [DW-1:0] mid = line1[rd_idx];
  wire [DW-1:0] top = (r_e == RW'(1)) ? mid : line2[rd_idx];
  wire [DW-1:0] bot = flush ? mid : in_pix;
  wire [3*DW-1:0] newcol = (c_e == END_COL) ? prev1 : {top, mid, bot};
  wire [3*DW-1:0] left   = (c_e == CW'(1)) ? prev1 : prev2;
  wire [DW-1:0] centre   = prev1[DW +: DW];

  logic [DW-1:0] win [9];
  logic signed [SW-1:0] acc, shifted, thr_s, edge_v, sum_v;
  logic [DW-1:0] result;

  always_comb begin
    for (int j = 0; j < 3; j++) begin
      for (int i = 0; i < 3; i++) begin
        if (j == 0)      win[3*i+j] = left[(2-i)*DW +: DW];
        else if (j == 1) win[3*i+j] = prev1[(2-i)*DW +: DW];
        else             win[3*i+j] = newcol[(2-i)*DW +: DW];
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < 9; k++)
      acc = acc + $signed({{(SW-DW){1'b0}}, win[k]})
                * $signed({{(SW-10){coef[10*k+9]}}, coef[10*k +: 10]});
    shifted = acc >>> shift;
    thr_s   = $signed({{(SW-6){1'b0}}, thresh});
    if (shifted > thr_s)       edge_v = shifted - thr_s;
    else if (shifted < -thr_s) edge_v = shifted + thr_s;
    else                       edge_v = '0;
    sum_v = $signed({{(SW-DW){1'b0}}, centre}) + edge_v;
    if (!en)                result = centre;
    else if (sum_v < 0)     result = '0;
    else if (sum_v > MAXV)  result = MAXV[DW-1:0];
    else                    result = sum_v[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (adv && need_in) begin
      line1[rd_idx] <= in_pix;
      line2[rd_idx] <= mid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      prev1 <= '0;
      prev2 <= '0;
      out_valid <= 1'b0;
      out_pix <= '0;
      out_sof <= 1'b0;
      out_eol <= 1'b0;
    end else begin
      if (adv) begin
        prev2 <= prev1;
        prev1 <= newcol;
        if (c_e == END_COL) begin
          col <= '0;
          row <= flush ? '0 : r_e + RW'(1);
        end else begin
          col <= c_e + CW'(1);
          row <= r_e;
        end
      end
      if (out_free) begin
        out_valid <= adv && produce;
        if (adv && produce) begin
          out_pix <= result;
          out_sof <= (r_e == RW'(1)) && (c_e == CW'(1));
          out_eol <= (c_e == END_COL);
        end
      end
    end
  end

  logic [CW-1:0] ocnt;
  always_ff @(posedge clk) begin
    if (!rst_n) ocnt <= '0;
    else if (out_valid && out_ready) ocnt <= out_eol ? '0 : ocnt + CW'(1);
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_eol));
  assert_eol_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eol |-> ocnt == CW'(WIDTH - 1));
  assert_sof_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> ocnt == '0);
  assert_in_eol_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_eol && !in_sof |-> col == CW'(WIDTH - 1));
endmodule

// File: tb/test_luma_edge_enhancer.sv
module test_luma_edge_enhancer;
  localparam int W = 6;
  localparam int H = 4;
  localparam int N = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [89:0] coef = '0;
  logic [3:0] shift = '0;
  logic [5:0] thresh = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, out_ready = 1'b0;
  logic [7:0] in_pix = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [7:0] out_pix;

  int total = 0, bad = 0, cyc = 0;
  int img [H][W];
  int cf [9];
  bit done = 0;

  always #2 clk = ~clk;

  luma_edge_enhancer #(.WIDTH(W), .HEIGHT(H), .DW(8)) i_luma_edge_enhancer (
    .clk(clk), .rst_n(rst_n), .en(en), .coef(coef), .shift(shift), .thresh(thresh),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol));

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cl(int v, int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  function automatic int model(int r, int c);
    int s = 0, e, y;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        s += img[cl(r+i-1, H-1)][cl(c+j-1, W-1)] * cf[3*i+j];
    if (!en) return img[r][c];
    s = s >>> shift;
    if (s > int'(thresh)) e = s - int'(thresh);
    else if (s < -int'(thresh)) e = s + int'(thresh);
    else e = 0;
    y = img[r][c] + e;
    return cl(y, 255);
  endfunction

  task automatic set_cfg(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7, int c8,
                         int sh, int th, bit on);
    cf = '{c0, c1, c2, c3, c4, c5, c6, c7, c8};
    for (int k = 0; k < 9; k++) coef[10*k +: 10] = 10'(cf[k]);
    shift = 4'(sh);
    thresh = 6'(th);
    en = on;
  endtask

  task automatic run_frame(string req, bit vgap, bit rgap);
    int fed = 0, got = 0, start = cyc, last_in = 0;
    while (got < N && cyc - start < 5000) begin
      @(negedge clk);
      in_valid = (fed < N) && !(vgap && (cyc % 3 == 1));
      in_pix = 8'(img[fed / W][fed % W]);
      in_sof = (fed == 0);
      in_eol = (fed % W == W - 1);
      out_ready = !(rgap && (cyc % 4 >= 2));
      #1;
      if (in_valid && in_ready) begin
        fed++;
        last_in = cyc;
      end
      if (out_valid && out_ready) begin
        check(req, "pixel", int'(out_pix), model(got / W, got % W));
        check("R8", "markers", {out_sof, out_eol}, {got == 0, got % W == W - 1});
        got++;
      end
    end
    in_valid = 1'b0;
    check("R10", "pixels per frame", got, N);
    out_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      #1;
      if (out_valid) begin
        check("R10", "extra output after frame", 1, 0);
        break;
      end
    end
    if (!vgap) check("R10", "drained without input", int'(got == N && last_in <= cyc), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_identity();
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = r * 40 + c * 7;
    set_cfg(0, 0, 0, 0, 16, 0, 0, 0, 0, 4, 0, 1);
    run_frame("R2 R5", 0, 0);
  endtask

  task automatic t_laplace();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = (r >= 1 && r <= 2 && c >= 2 && c <= 3) ? 200 : 50;
    set_cfg(-1, -1, -1, -1, 8, -1, -1, -1, -1, 2, 5, 1);
    run_frame("R4 R6", 0, 0);
  endtask

  task automatic t_negshift();
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = (r * 37 + c * 91 + 13) % 256;
    set_cfg(-3, 0, 5, -7, 1, 0, 2, -512, 511, 3, 0, 1);
    run_frame("R3", 0, 0);
    set_cfg(1, -2, 1, -2, 4, -2, 1, -2, 1, 1, 63, 1);
    run_frame("R4", 0, 0);
  endtask

  task automatic t_bypass();
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = (r * 53 + c * 29 + 200) % 256;
    set_cfg(511, -512, 300, -1, 77, 9, -200, 5, 1, 0, 0, 0);
    run_frame("R7", 0, 0);
  endtask

  task automatic t_stall();
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = (r * 71 + c * 113) % 256;
    set_cfg(-1, -2, -1, 0, 20, 0, 1, 2, 1, 2, 3, 1);
    run_frame("R9", 1, 1);
  endtask

  task automatic t_resync();
    int seen = 0;
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_pix = 8'(k * 60);
      in_sof = (k == 0);
      in_eol = 1'b0;
      #1;
      if (out_valid) seen++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    if (out_valid) seen++;
    check("R11", "output from partial frame", seen, 0);
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = (r * 17 + c * 45 + 9) % 256;
    set_cfg(0, -1, 0, -1, 6, -1, 0, -1, 0, 1, 2, 1);
    run_frame("R11", 0, 0);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_identity();
    t_laplace();
    t_negshift();
    t_bypass();
    t_stall();
    t_resync();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule